// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave serial port that lets an external host read and write a bank of 26 byte-wide configuration registers at addresses 0x00 to 0x19. The serial clock is the block's clock. Every access opens with an 8-bit command byte carrying the transfer direction, a byte count from one to four, and a starting address. The data bytes follow, and the port steps the register address on its own after each byte.

Register 0x00 configures the port. Bit 6 selects the bit order and, through it, the address step direction. With MSB-first order the address counts down. With LSB-first order it counts up. Bit 7 moves read data from the shared data pin to a dedicated output pin. A write to this register acts at once, part way through a multibyte cycle. The host can suspend a cycle with the chip select and resume it later. A separate sync input aborts the cycle and leaves the register contents as they were. All register bytes are brought out in parallel for the datapath that uses them.

Top module: `sercfg_port`

## Requirements
- R1: The command byte holds the direction in bit 7 (1 = read, 0 = write), the byte count minus one in bits 6:5, and the start address in bits 4:0. A written data byte appears on `regs_q` once its eighth bit has been clocked in.
- R2: With register 0x00 bit 6 at 0, command and data bits travel most significant bit first, and the address decrements after each byte, wrapping from 0x00 to 0x19.
- R3: With register 0x00 bit 6 at 1, command and data bits travel least significant bit first, and the address increments after each byte, wrapping from 0x19 to 0x00.
- R4: With register 0x00 bit 7 at 0, read data leaves on `sdio_out` with `sdio_oe` high and `sdo_oe` low. With bit 7 at 1, read data leaves on `sdo_out` and `sdio_oe` stays low.
- R5: A write to register 0x00 changes the bit order and step direction for the remaining bytes of the same cycle.
- R6: While `cs_n` is high, both output enables are low and rising clock edges leave the cycle untouched. The cycle resumes at the same bit once `cs_n` returns low.
- R7: `sync` high on a rising edge aborts the cycle and discards a partly received byte. The next 8 bits are taken as a command, and register contents are unchanged.
- R8: After the commanded number of bytes, the next 8 bits are decoded as a new command.
- R9: Read data changes only on falling clock edges. An output enable is high only during the data bytes of a read.
- R10: A synchronous reset clears every register to 0x00 and returns the port to the command phase.
- R11: Writes to addresses 0x1A to 0x1F change no register, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock, the clock of the block |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select, suspends while high |
| sync | input | 1 | Cycle abort, active high |
| sdio_in | input | 1 | Serial data input, sampled on rising edges |
| sdio_out | output | 1 | Read data for the shared data pin |
| sdio_oe | output | 1 | Output enable of the shared data pin |
| sdo_out | output | 1 | Read data for the dedicated output pin |
| sdo_oe | output | 1 | Output enable of the dedicated output pin |
| regs_q | output | 208 | All registers, register n in bits 8n+7:8n |

## Verification
Single-byte write-and-read pairs over a table of addresses and data show that the command fields and both data paths decode correctly. Multibyte bursts that start next to the range ends show whether the step direction follows the bit order and whether the wrap point is correct. A burst whose first byte rewrites register 0x00 shows that the configuration changes part way through a cycle. Separate sequences interrupt cycles with chip select pauses, sync pulses and overrun clocks, and these show the difference between a suspend, an abort and a new command.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    localparam int NUM_REGS  = 26;
    localparam int ADDR_W    = 5;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 2;
    localparam int BIT_IDX_W = $clog2(BYTE_W);
    localparam int FLAT_W    = NUM_REGS * BYTE_W;

    // configuration register and its fields
    localparam int CFG_ADDR  = 0;
    localparam int ORDER_BIT = 6;
    localparam int PIN_BIT   = 7;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    // next byte address: up for LSB-first, down for MSB-first
    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                    input logic up);
        if (up)
            return (a >= ADDR_W'(NUM_REGS - 1)) ? '0 : a + 1'b1;
        else
            return (a == '0) ? ADDR_W'(NUM_REGS - 1) : a - 1'b1;
    endfunction

endpackage

// File: rtl/sercfg_shifter.sv
module sercfg_shifter
    import sercfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 din,
    input  logic                 lsb_first,
    output logic                 byte_done,
    output logic [BYTE_W-1:0]    byte_val,
    output logic [BIT_IDX_W-1:0] bit_idx
);

    logic [BYTE_W-1:0]    sr_q;
    logic [BIT_IDX_W-1:0] cnt_q;
    logic                 last_bit;

    assign last_bit  = (cnt_q == BIT_IDX_W'(BYTE_W - 1));
    assign byte_val  = lsb_first ? {din, sr_q[BYTE_W-1:1]} : {sr_q[BYTE_W-2:0], din};
    assign byte_done = en && !clr && last_bit;
    assign bit_idx   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (en) begin
            cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
            sr_q  <= byte_val;
        end
    end

    // R6: no shifting while the port is not selected
    p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt_q) && $stable(sr_q));

endmodule

// File: rtl/sercfg_regbank.sv
module sercfg_regbank
    import sercfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata,
    output logic [FLAT_W-1:0] regs_flat
);

    logic [BYTE_W-1:0] mem_q [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < NUM_REGS; i++)
                if (waddr == ADDR_W'(i)) mem_q[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (raddr == ADDR_W'(i)) rdata = mem_q[i];
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_flat[g*BYTE_W +: BYTE_W] = mem_q[g];
    end

    // R11: an address past the bank leaves every register alone
    p_oor_write_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (we && waddr >= ADDR_W'(NUM_REGS)) |=> $stable(regs_flat));

endmodule

// File: rtl/sercfg_port.sv
module sercfg_port
    import sercfg_pkg::*;
(
    input  logic              sclk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sync,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              sdo_out,
    output logic              sdo_oe,
    output logic [FLAT_W-1:0] regs_q
);

    phase_e               phase_q;
    logic                 rd_q;
    logic [CNT_W-1:0]     left_q;
    logic [ADDR_W-1:0]    addr_q;

    logic                 byte_done;
    logic [BYTE_W-1:0]    byte_val;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic [BYTE_W-1:0]    rdata;
    logic                 we;
    logic                 lsb_first;
    logic                 pin_sep;
    logic                 step_up;
    logic                 selected;
    cmd_t                 cmd;

    logic                 dout_q;
    logic                 oe_q;
    logic [BIT_IDX_W-1:0] out_sel;

    assign lsb_first = regs_q[CFG_ADDR*BYTE_W + ORDER_BIT];
    assign pin_sep   = regs_q[CFG_ADDR*BYTE_W + PIN_BIT];
    assign selected  = !cs_n && !sync;
    assign cmd       = cmd_t'(byte_val);
    assign we        = byte_done && (phase_q == PH_DATA) && !rd_q;

    // a byte landing in the configuration register steers the next step at once
    assign step_up = (we && addr_q == ADDR_W'(CFG_ADDR)) ? byte_val[ORDER_BIT] : lsb_first;

    sercfg_shifter u_shift (
        .clk       (sclk),
        .rst       (rst),
        .clr       (sync),
        .en        (selected),
        .din       (sdio_in),
        .lsb_first (lsb_first),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .bit_idx   (bit_idx)
    );

    sercfg_regbank u_bank (
        .clk       (sclk),
        .rst       (rst),
        .we        (we),
        .waddr     (addr_q),
        .wdata     (byte_val),
        .raddr     (addr_q),
        .rdata     (rdata),
        .regs_flat (regs_q)
    );

    // cycle sequencer, rising edge
    always_ff @(posedge sclk) begin
        if (rst || sync) begin
            phase_q <= PH_CMD;
            rd_q    <= 1'b0;
            left_q  <= '0;
            addr_q  <= '0;
        end else if (byte_done) begin
            if (phase_q == PH_CMD) begin
                phase_q <= PH_DATA;
                rd_q    <= cmd.rd;
                left_q  <= cmd.cnt;
                addr_q  <= cmd.addr;
            end else begin
                addr_q <= step_addr(addr_q, step_up);
                left_q <= left_q - 1'b1;
                if (left_q == '0) phase_q <= PH_CMD;
            end
        end
    end

    // read launch, falling edge
    assign out_sel = lsb_first ? bit_idx : BIT_IDX_W'(BYTE_W - 1) - bit_idx;

    always_ff @(negedge sclk) begin
        if (rst) begin
            dout_q <= 1'b0;
            oe_q   <= 1'b0;
        end else if (!cs_n) begin
            oe_q   <= (phase_q == PH_DATA) && rd_q && !sync;
            dout_q <= rdata[out_sel];
        end
    end

    assign sdio_out = dout_q;
    assign sdo_out  = dout_q;
    assign sdio_oe  = oe_q && !cs_n && !pin_sep;
    assign sdo_oe   = oe_q && !cs_n && pin_sep;

    // R6: a deselected port keeps its place in the cycle
    p_cs_suspend_r6: assert property (@(posedge sclk) disable iff (rst)
        (cs_n && !sync) |=> $stable(phase_q) && $stable(addr_q) && $stable(left_q));

    // R7: sync returns the port to the command phase
    p_sync_abort_r7: assert property (@(posedge sclk) disable iff (rst)
        sync |=> (phase_q == PH_CMD) && (bit_idx == '0));

    // R4: never both pins driven
    p_single_driver_r4: assert property (@(posedge sclk) disable iff (rst)
        !(sdio_oe && sdo_oe));

    // R9: an enabled output belongs to a read cycle
    p_oe_only_read_r9: assert property (@(posedge sclk) disable iff (rst)
        (sdio_oe || sdo_oe) |-> rd_q);

    // R2/R3: an in-range burst address never leaves the bank
    p_addr_in_bank_r2: assert property (@(posedge sclk) disable iff (rst || sync)
        (phase_q == PH_DATA && addr_q < ADDR_W'(NUM_REGS)) |=> addr_q < ADDR_W'(NUM_REGS));

endmodule

// File: tb/sercfg_port_test.sv
`timescale 1ns/1ps
module sercfg_port_test;

    logic         sclk = 1'b0;
    logic         rst;
    logic         cs_n;
    logic         sync;
    logic         sdio_in;
    logic         sdio_out, sdio_oe, sdo_out, sdo_oe;
    logic [207:0] regs_q;

    int checks = 0;
    int fails  = 0;
    bit lsb_tb = 0;
    bit pin_tb = 0;
    logic oe_act, oe_other;
    bit pause_oe_bad, edge_bad, read_oe_low, read_wrong_oe, in_read;
    bit done = 0;

    always #2.5 sclk = ~sclk;

    sercfg_port uut (
        .sclk(sclk), .rst(rst), .cs_n(cs_n), .sync(sync), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
        .regs_q(regs_q)
    );

    // stimulus table: {address, data}, single-byte write then read back
    localparam logic [12:0] VEC [8] = '{
        {5'd1,  8'hA5}, {5'd2,  8'h3C}, {5'd5,  8'hFF}, {5'd9,  8'h01},
        {5'd13, 8'h80}, {5'd17, 8'h5A}, {5'd24, 8'hC3}, {5'd25, 8'h7E}
    };

    function automatic logic [7:0] rg(input int i);
        return regs_q[i*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b, output logic r);
        @(negedge sclk);
        cs_n    = 1'b0;
        sdio_in = b;
        #1;
        r        = pin_tb ? sdo_out : sdio_out;
        oe_act   = pin_tb ? sdo_oe : sdio_oe;
        oe_other = pin_tb ? sdio_oe : sdo_oe;
        if (in_read) begin
            if (!oe_act) read_oe_low = 1;
            if (oe_other) read_wrong_oe = 1;
        end
        @(posedge sclk);
        #1;
        if (in_read && ((pin_tb ? sdo_out : sdio_out) !== r)) edge_bad = 1;
    endtask

    task automatic xfer_byte(input logic [7:0] b, input int pause_at, output logic [7:0] r);
        logic bv;
        for (int i = 0; i < 8; i++) begin
            int idx = lsb_tb ? i : 7 - i;
            if (i == pause_at) begin
                repeat (3) begin
                    @(negedge sclk);
                    cs_n    = 1'b1;
                    sdio_in = ~sdio_in;
                    #1;
                    if (sdio_oe || sdo_oe) pause_oe_bad = 1;
                end
            end
            clk_bit(b[idx], bv);
            r[idx] = bv;
        end
    endtask

    task automatic end_tx;
        cs_n = 1'b1;
        @(negedge sclk);
    endtask

    task automatic send_cmd(input bit rd, input int n, input logic [4:0] a);
        logic [7:0] dummy;
        xfer_byte({rd, 2'(n - 1), a}, -1, dummy);
    endtask

    task automatic wr1(input logic [4:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        send_cmd(0, 1, a);
        xfer_byte(d, -1, dummy);
        end_tx();
    endtask

    task automatic rd1(input logic [4:0] a, output logic [7:0] d);
        send_cmd(1, 1, a);
        in_read = 1;
        xfer_byte(8'h00, -1, d);
        in_read = 0;
        end_tx();
    endtask

    task automatic sync_pulse;
        @(negedge sclk);
        cs_n = 1'b1;
        sync = 1'b1;
        @(negedge sclk);
        sync = 1'b0;
    endtask

    initial begin
        #500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, r2, dummy;
        rst = 1'b1; cs_n = 1'b1; sync = 1'b0; sdio_in = 1'b0;
        repeat (3) @(negedge sclk);
        rst = 1'b0;
        @(negedge sclk);
        #1;
        // R10: reset state
        chk("R10 regs after reset", {24'd0, rg(0)} | (|regs_q), 32'd0);
        chk("R10 outputs idle", {sdio_oe, sdo_oe}, 2'b00);

        // R1 R2: table of single-byte writes and reads, MSB-first
        for (int v = 0; v < 8; v++) begin
            wr1(VEC[v][12:8], VEC[v][7:0]);
            chk("R1 write lands", rg(int'(VEC[v][12:8])), VEC[v][7:0]);
            read_oe_low = 0; read_wrong_oe = 0;
            rd1(VEC[v][12:8], r);
            chk("R1 read back", r, VEC[v][7:0]);
        end
        chk("R4 read on shared pin, enables", {read_oe_low, read_wrong_oe}, 2'b00);
        chk("R9 data stable across rising edge", edge_bad, 0);

        // R2: MSB-first burst 1,0,25 (decrement and wrap)
        send_cmd(0, 3, 5'd1);
        xfer_byte(8'h11, -1, dummy);
        xfer_byte(8'h00, -1, dummy);
        xfer_byte(8'h33, -1, dummy);
        end_tx();
        chk("R2 burst addr 1", rg(1), 8'h11);
        chk("R2 burst wrap to 25", rg(25), 8'h33);
        send_cmd(1, 2, 5'd2);
        in_read = 1;
        xfer_byte(8'h00, -1, r);
        xfer_byte(8'h00, -1, r2);
        in_read = 0;
        end_tx();
        chk("R2 burst read addr 2", r, 8'h3C);
        chk("R2 burst read addr 1", r2, 8'h11);

        // R11: outside the bank
        wr1(5'd28, 8'hFF);
        chk("R11 write beyond bank ignored", rg(25), 8'h33);
        chk("R11 write beyond bank ignored (cfg)", rg(0), 8'h00);
        rd1(5'd28, r);
        chk("R11 read beyond bank", r, 8'h00);

        // R6: suspend in the middle of a write and of a read
        pause_oe_bad = 0;
        send_cmd(0, 1, 5'd3);
        xfer_byte(8'hB6, 4, dummy);
        end_tx();
        chk("R6 write resumes after cs pause", rg(3), 8'hB6);
        send_cmd(1, 1, 5'd3);
        in_read = 1;
        xfer_byte(8'h00, 3, r);
        in_read = 0;
        end_tx();
        chk("R6 read resumes after cs pause", r, 8'hB6);
        chk("R6 enables low while deselected", pause_oe_bad, 0);

        // R9: enable drops right after the read data phase
        send_cmd(1, 1, 5'd3);
        in_read = 1;
        xfer_byte(8'h00, -1, r);
        in_read = 0;
        clk_bit(1'b0, r[0]);
        chk("R9 enable low after read bytes", {oe_act, oe_other}, 2'b00);
        sync_pulse();

        // R7: abort mid-command and mid-data
        for (int i = 0; i < 5; i++) clk_bit(1'b1, r[0]);
        sync_pulse();
        wr1(5'd4, 8'h5A);
        chk("R7 command after abort", rg(4), 8'h5A);
        send_cmd(0, 1, 5'd4);
        for (int i = 0; i < 3; i++) clk_bit(1'b1, r[0]);
        sync_pulse();
        chk("R7 partial byte discarded", rg(4), 8'h5A);
        wr1(5'd8, 8'h88);
        chk("R7 port usable after data abort", rg(8), 8'h88);

        // R8: extra clocks become the next command
        send_cmd(0, 1, 5'd6);
        xfer_byte(8'h66, -1, dummy);
        xfer_byte({1'b0, 2'b00, 5'd7}, -1, dummy);
        xfer_byte(8'h77, -1, dummy);
        end_tx();
        chk("R8 first write", rg(6), 8'h66);
        chk("R8 overrun decoded as command", rg(7), 8'h77);

        // R4: dedicated output pin
        wr1(5'd0, 8'h80);
        pin_tb = 1;
        read_oe_low = 0; read_wrong_oe = 0;
        rd1(5'd1, r);
        chk("R4 read on dedicated pin", r, 8'h11);
        chk("R4 shared pin stays released", {read_oe_low, read_wrong_oe}, 2'b00);
        wr1(5'd0, 8'h00);
        pin_tb = 0;

        // R3: LSB-first, increment and wrap 25 -> 0
        wr1(5'd0, 8'h40);
        lsb_tb = 1;
        send_cmd(0, 2, 5'd25);
        xfer_byte(8'h5C, -1, dummy);
        xfer_byte(8'h40, -1, dummy);
        end_tx();
        chk("R3 LSB burst addr 25", rg(25), 8'h5C);
        chk("R3 LSB burst wrap to 0", rg(0), 8'h40);
        send_cmd(1, 2, 5'd24);
        in_read = 1;
        xfer_byte(8'h00, -1, r);
        xfer_byte(8'h00, -1, r2);
        in_read = 0;
        end_tx();
        chk("R3 LSB read addr 24", r, 8'hC3);
        chk("R3 LSB read addr 25", r2, 8'h5C);

        // R5: switch back to MSB-first in the middle of a burst
        send_cmd(0, 2, 5'd0);
        xfer_byte(8'h00, -1, dummy);
        lsb_tb = 0;
        xfer_byte(8'h99, -1, dummy);
        end_tx();
        chk("R5 cfg rewritten", rg(0), 8'h00);
        chk("R5 next byte uses new order and step", rg(25), 8'h99);
        chk("R5 increment path not taken", rg(1), 8'h11);

        // R10: reset mid-use
        @(negedge sclk);
        rst = 1'b1;
        repeat (2) @(negedge sclk);
        rst = 1'b0;
        #1;
        chk("R10 reset clears bank", {31'd0, |regs_q}, 32'd0);
        wr1(5'd12, 8'h12);
        chk("R10 command phase after reset", rg(12), 8'h12);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule